// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Sample Voting

This block recovers characters from an asynchronous serial line. A free-running tick input, produced elsewhere, marks each moment at which the line is sampled. In normal-speed mode every bit spans 16 ticks. In double-speed mode every bit spans 8 ticks. The line first passes through a two-flop synchronizer. The sampled value is then watched for a falling edge. Each bit of the frame is decided by a majority vote of three consecutive samples taken around the bit centre. This applies to the start bit, the data bits, the optional parity bit and the stop bit.

The character length (5 to 9 data bits) and the parity scheme (none, even or odd) are static configuration inputs. When the stop bit has been voted, the character and its frame and parity error flags appear together with a one-cycle valid strobe. The receiver returns to edge search right after the last voting sample of the stop bit. This lets a following frame begin before a full-length stop bit has elapsed.

Top module: `uart_os_rx`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rx_valid, frame_err and parity_err are 0 and rx_data is 0.
- R2: With dbl_speed=0 a bit lasts 16 sample ticks. With dbl_speed=1 it lasts 8 sample ticks. Frames sent at either rate are received correctly.
- R3: Sample 1 of the start bit is the first tick that sees the line low. Each bit is decided by the majority of its samples 8, 9 and 10 in normal-speed mode, or 4, 5 and 6 in double-speed mode. A single disagreeing sample among the three does not change the bit.
- R4: If the start bit votes 1, the frame is discarded: no strobe is produced and the receiver searches for the next falling edge.
- R5: Data bits arrive LSB first. A character of char_bits bits (5 to 9) is placed in rx_data starting at bit 0, and the unused upper bits are 0.
- R6: When parity_en=1, one parity bit follows the data. With parity_odd=0 the data plus the parity bit must hold an even number of ones, and with parity_odd=1 an odd number. A mismatch sets parity_err. When parity_en=0, no parity bit is expected and parity_err stays 0.
- R7: If the stop bit votes 0, frame_err is set together with that character.
- R8: rx_valid is high for exactly one clock per accepted frame, in the same cycle that rx_data and the flags take their new values. The flags hold until the next start edge is detected, and are cleared then.
- R9: A falling edge on the first tick after the last voting sample of the stop bit is accepted as the start of the next frame.
- R10: A frame begins only on a high-to-low transition of the sampled line. A line that stays low after a frame error starts no new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse for each oversampling instant |
| rxd | input | 1 | Asynchronous serial line, idle high |
| dbl_speed | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| char_bits | input | 4 | Data bits per character, 5 to 9 |
| parity_en | input | 1 | A parity bit follows the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_data | output | 9 | Last received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| frame_err | output | 1 | Stop bit of the last character voted 0 |
| parity_err | output | 1 | Parity of the last character mismatched |

## Verification
Assertions check the following on every cycle: the strobe lasts one cycle, the strobe follows only a stop-bit vote, votes fall on sample ticks, the sample counter stays in range, the flags are clear on entry to a new frame, and a rejected start returns the receiver to idle. Only the bench scenarios can show the remaining behaviour. These are the vote positions, where a lone flipped sample is outvoted and short or late glitches on the start bit are rejected. They also cover the correct bit order and parity for every length, the frame error on a held-low stop bit with no false restart, and back-to-back frames whose start edge follows the stop-bit vote immediately in both speed modes.

// File: rtl/uart_os_rx_pkg.sv
// Shared types and helpers for the oversampled serial receiver.
package uart_os_rx_pkg;

    // Frame sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    // Two-out-of-three majority.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
// Multi-stage synchronizer for the asynchronous line.
// Assumes the line idles high, so every stage resets to 1.
module uart_os_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_sampler.sv
// Counts sample ticks within a bit and produces one majority vote per bit.
// Assumes restart is raised only on a tick while run is low. The sample
// taken on that tick is numbered 1. The vote strobe is combinational and
// coincides with the tick of the third voting sample.
module uart_os_rx_sampler
    import uart_os_rx_pkg::*;
#(
    parameter int OS_NORMAL = 16,
    parameter int OS_DOUBLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dbl,
    input  logic restart,
    input  logic run,
    input  logic line,
    output logic vote_stb,
    output logic vote_bit
);
    localparam int CW = $clog2(OS_NORMAL + 1);
    localparam logic [CW-1:0] LEN_N = CW'(OS_NORMAL);
    localparam logic [CW-1:0] LEN_D = CW'(OS_DOUBLE);
    localparam logic [CW-1:0] MID_N = CW'(OS_NORMAL / 2 + 1);
    localparam logic [CW-1:0] MID_D = CW'(OS_DOUBLE / 2 + 1);

    logic [CW-1:0] cnt, idx, len, mid;
    logic          s_a, s_b;

    // Select bit length and centre for the mode, and number the current sample.
    always_comb begin
        len = dbl ? LEN_D : LEN_N;
        mid = dbl ? MID_D : MID_N;
        idx = (cnt >= len) ? CW'(1) : cnt + CW'(1);
    end

    // Advance the sample count and capture the first two voting samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            s_a <= 1'b1;
            s_b <= 1'b1;
        end else if (tick) begin
            if (restart) begin
                cnt <= CW'(1);
            end else if (run) begin
                cnt <= idx;
                if (idx == mid - CW'(1)) s_a <= line;
                if (idx == mid)          s_b <= line;
            end
        end
    end

    assign vote_stb = tick && run && !restart && (idx == mid + CW'(1));
    assign vote_bit = maj3(s_a, s_b, line);

    // R3: a vote is only ever taken on a sample tick.
    p_vote_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vote_stb |-> tick);

    // R2: the sample count never runs past the longest bit.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LEN_N);
endmodule

// File: rtl/uart_os_rx_frame.sv
// Frame sequencer: detects the start edge, checks the start bit, assembles
// data LSB first, checks parity and stop, and presents the result.
// Assumes the configuration inputs stay static during a frame.
module uart_os_rx_frame
    import uart_os_rx_pkg::*;
#(
    parameter int MAX_BITS = 9,
    parameter int MIN_BITS = 5,
    localparam int IW = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic [IW-1:0]       char_bits,
    input  logic                parity_en,
    input  logic                parity_odd,
    input  logic                vote_stb,
    input  logic                vote_bit,
    output logic                restart,
    output logic                run,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                frame_err,
    output logic                parity_err
);
    localparam logic [IW-1:0] MINB = IW'(MIN_BITS);
    localparam logic [IW-1:0] MAXB = IW'(MAX_BITS);

    rx_state_t           state;
    logic [IW-1:0]       bit_idx, nbits;
    logic [MAX_BITS-1:0] shreg;
    logic                pbit, line_prev;

    // Clamp the configured length into the supported range.
    always_comb begin
        if (char_bits < MINB)      nbits = MINB;
        else if (char_bits > MAXB) nbits = MAXB;
        else                       nbits = char_bits;
    end

    assign restart = (state == ST_IDLE) && tick && line_prev && !line;
    assign run     = (state != ST_IDLE);

    // Frame sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_idx    <= '0;
            shreg      <= '0;
            pbit       <= 1'b0;
            line_prev  <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tick) line_prev <= line;
                    if (restart) begin
                        state      <= ST_START;
                        frame_err  <= 1'b0;
                        parity_err <= 1'b0;
                    end
                end
                ST_START: begin
                    if (vote_stb) begin
                        if (!vote_bit) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                            shreg   <= '0;
                        end else begin
                            state     <= ST_IDLE;
                            line_prev <= line;
                        end
                    end
                end
                ST_DATA: begin
                    if (vote_stb) begin
                        shreg[bit_idx] <= vote_bit;
                        if (bit_idx == nbits - IW'(1))
                            state <= parity_en ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + IW'(1);
                    end
                end
                ST_PARITY: begin
                    if (vote_stb) begin
                        pbit  <= vote_bit;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (vote_stb) begin
                        rx_data    <= shreg;
                        rx_valid   <= 1'b1;
                        frame_err  <= !vote_bit;
                        parity_err <= parity_en && ((^shreg) ^ pbit ^ parity_odd);
                        state      <= ST_IDLE;
                        line_prev  <= line;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: the strobe never lasts longer than one clock.
    p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: both flags are clear once a new frame has been entered.
    p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) == ST_IDLE) |-> (!frame_err && !parity_err));

    // R7: a strobe only follows the stop-bit state.
    p_valid_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state) == ST_STOP);

    // R4: a start bit voted high returns to idle with no strobe.
    p_start_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && vote_stb && vote_bit) |=> (state == ST_IDLE && !rx_valid));
endmodule

// File: rtl/uart_os_rx.sv
// Top of the oversampled serial receiver: synchronizer, tick-domain
// sampler with majority vote, and frame sequencer.
// Assumes sample_tick is a single-cycle pulse at 16x or 8x the bit rate.
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int MAX_BITS  = 9,
    parameter int OS_NORMAL = 16,
    parameter int OS_DOUBLE = 8,
    parameter int SYNC_FF   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sample_tick,
    input  logic                              rxd,
    input  logic                              dbl_speed,
    input  logic [$clog2(MAX_BITS+1)-1:0]     char_bits,
    input  logic                              parity_en,
    input  logic                              parity_odd,
    output logic [MAX_BITS-1:0]               rx_data,
    output logic                              rx_valid,
    output logic                              frame_err,
    output logic                              parity_err
);
    logic line_s, vote_stb, vote_bit, restart, run;

    uart_os_rx_sync #(.STAGES(SYNC_FF)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    uart_os_rx_sampler #(.OS_NORMAL(OS_NORMAL), .OS_DOUBLE(OS_DOUBLE)) smp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_tick),
        .dbl     (dbl_speed),
        .restart (restart),
        .run     (run),
        .line    (line_s),
        .vote_stb(vote_stb),
        .vote_bit(vote_bit)
    );

    uart_os_rx_frame #(.MAX_BITS(MAX_BITS)) frm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .line      (line_s),
        .char_bits (char_bits),
        .parity_en (parity_en),
        .parity_odd(parity_odd),
        .vote_stb  (vote_stb),
        .vote_bit  (vote_bit),
        .restart   (restart),
        .run       (run),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .frame_err (frame_err),
        .parity_err(parity_err)
    );
endmodule

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       dbl = 1'b0;
    logic [3:0] cbits = 4'd8;
    logic       pen = 1'b0;
    logic       podd = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, frame_err, parity_err;

    int errors = 0;
    int checks = 0;
    int cap_n = 0;
    logic [8:0] cap_data [0:255];
    logic       cap_fe   [0:255];
    logic       cap_pe   [0:255];
    int tdiv = 0;

    uart_os_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sample_tick(tick), .rxd(rxd),
        .dbl_speed(dbl), .char_bits(cbits), .parity_en(pen), .parity_odd(podd),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
        .parity_err(parity_err)
    );

    always #2 clk = ~clk;

    // Tick generator: one pulse every DIV clocks.
    always @(posedge clk) begin
        tdiv <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == DIV - 1);
    end

    // Capture every strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (cap_n < 256) begin
                cap_data[cap_n] = rx_data;
                cap_fe[cap_n]   = frame_err;
                cap_pe[cap_n]   = parity_err;
            end
            cap_n++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Hold the line at val for n sampled ticks; ends just after a sampled tick.
    task automatic hold(input logic val, input int n);
        rxd = val;
        for (int i = 0; i < n; i++) begin
            while (!tick) @(negedge clk);
            @(negedge clk);
        end
    endtask

    function automatic int spb();
        return dbl ? 8 : 16;
    endfunction

    function automatic logic par_of(input logic [8:0] d, input int n, input logic odd);
        logic p = odd;
        for (int i = 0; i < n; i++) p ^= d[i];
        return p;
    endfunction

    // Send one frame. noisy: index of a data bit whose middle vote sample is flipped (-1 none).
    task automatic send(input logic [8:0] d, input int noisy, input logic pflip,
                        input logic stop_val, input int stop_ticks);
        int s = spb();
        int m = s / 2 + 1;
        hold(1'b0, s);
        for (int i = 0; i < int'(cbits); i++) begin
            if (i == noisy) begin
                hold(d[i], m - 1);
                hold(~d[i], 1);
                hold(d[i], s - m);
            end else begin
                hold(d[i], s);
            end
        end
        if (pen) hold(par_of(d, int'(cbits), podd) ^ pflip, s);
        hold(stop_val, stop_ticks);
    endtask

    task automatic expect_cap(input int idx, input logic [8:0] d, input logic fe,
                              input logic pe, input string req);
        logic [8:0] m = d & 9'((1 << int'(cbits)) - 1);
        check(cap_n > idx, req, cap_n, idx + 1);
        if (cap_n > idx) begin
            check(cap_data[idx] == m, req, cap_data[idx], m);
            check(cap_fe[idx] == fe, req, cap_fe[idx], fe);
            check(cap_pe[idx] == pe, req, cap_pe[idx], pe);
        end
    endtask

    initial begin
        int base;
        logic [8:0] d;
        bit done = 0;
        void'($urandom(32'd2024));
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                // R1: reset state
                check(rx_valid == 0 && frame_err == 0 && parity_err == 0 && rx_data == 0,
                      "R1", {rx_valid, frame_err, parity_err, rx_data}, 0);
                rst_n = 1'b1;
                hold(1'b1, 20);

                for (int md = 0; md < 2; md++) begin
                    dbl = md[0];
                    cbits = 4'd8; pen = 1'b0;
                    // R2/R5: plain 8-bit frame
                    base = cap_n;
                    send(9'h0A5, -1, 0, 1'b1, spb());
                    expect_cap(base, 9'h0A5, 0, 0, "R2 R5 basic");
                    // R3: lone flipped vote sample is outvoted
                    base = cap_n;
                    send(9'h03C, 2, 0, 1'b1, spb());
                    expect_cap(base, 9'h03C, 0, 0, "R3 noise");
                    // R4: short glitch on start
                    base = cap_n;
                    hold(1'b0, 2); hold(1'b1, 2 * spb());
                    check(cap_n == base, "R4 short glitch", cap_n, base);
                    // R4: glitch covering only first vote sample
                    hold(1'b0, spb() / 2); hold(1'b1, 2 * spb());
                    check(cap_n == base, "R4 late glitch", cap_n, base);
                    // R7/R10: stop held low, line stays low, no restart
                    send(9'h05A, -1, 0, 1'b0, 2 * spb());
                    hold(1'b1, 2 * spb());
                    check(cap_n == base + 1, "R10 no restart", cap_n, base + 1);
                    expect_cap(base, 9'h05A, 1, 0, "R7 frame error");
                    // R8: flags held until next start, cleared after the edge
                    check(frame_err == 1, "R8 hold", frame_err, 1);
                    hold(1'b0, 4);
                    check(frame_err == 0 && parity_err == 0, "R8 clear", frame_err, 0);
                    hold(1'b0, spb() - 4);
                    for (int i = 0; i < 8; i++) hold(i[0], spb());
                    hold(1'b1, spb());
                    expect_cap(base + 1, 9'h0AA, 0, 0, "R8 follow-up");
                    // R9: back-to-back with truncated stop, parity on
                    pen = 1'b1; podd = 1'b1; cbits = 4'd7;
                    base = cap_n;
                    send(9'h013, -1, 0, 1'b1, spb() / 2 + 2);
                    send(9'h06E, -1, 0, 1'b1, spb() / 2 + 2);
                    send(9'h041, -1, 0, 1'b1, spb());
                    check(cap_n == base + 3, "R9 count", cap_n, base + 3);
                    expect_cap(base, 9'h013, 0, 0, "R9 first");
                    expect_cap(base + 1, 9'h06E, 0, 0, "R9 second");
                    expect_cap(base + 2, 9'h041, 0, 0, "R9 third");
                    // R6: wrong parity bit
                    base = cap_n;
                    send(9'h055, -1, 1, 1'b1, spb());
                    expect_cap(base, 9'h055, 0, 1, "R6 parity error");
                    hold(1'b1, 4);
                end

                // Random frames, R2 R5 R6 R7
                for (int k = 0; k < 40; k++) begin
                    logic pf, sv;
                    dbl   = 1'($urandom_range(0, 1));
                    cbits = 4'($urandom_range(5, 9));
                    pen   = 1'($urandom_range(0, 1));
                    podd  = 1'($urandom_range(0, 1));
                    d     = 9'($urandom);
                    pf    = pen & ($urandom_range(0, 3) == 0);
                    sv    = ($urandom_range(0, 5) != 0);
                    base  = cap_n;
                    send(d, -1, pf, sv, spb());
                    hold(1'b1, spb());
                    expect_cap(base, d, !sv, pf, "R5 R6 R7 random");
                end
                done = 1;
            end
            begin
                repeat (190000) @(posedge clk);
                if (!done) check(0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule